// File: doc/BRIEF.md
# Fixed Off-Time Peak Current Chopper

This block limits the peak current in a motor winding by chopping the high-side drive cycle by cycle. A current-trip flag from an external comparator reports that the sensed current has reached the reference level. When the drive is on and armed, a trip drops the chop-enable output. That output is the source-enable latch towards the gate sequencer. It stays low for a programmable off time and then comes back on by itself.

Each time chop-enable rises, a programmable blanking window starts. During that window, trip assertions are ignored, so that the current spike from diode reverse recovery at turn-on cannot end the on time early. An external PWM input gates the whole function. Driven low, it forces chop-enable low from any state. Held high, it leaves the current limit as the only thing that shapes the drive. A one-cycle pulse reports every high-side turn-on.

The block is a four-state machine sharing one down counter:
- States: IDLE (PWM low, drive off), BLANK (drive on, trips ignored), ARMED (drive on, trips honoured) and OFF (fixed off time running).
- START: IDLE to BLANK when PWM is high.
- ARM: BLANK to ARMED when the blank count runs out.
- TRIP: ARMED to OFF on a trip.
- RESUME: OFF to BLANK when the off count runs out.
- GATE: any other state to IDLE when PWM is low. GATE takes priority over every other transition.

Top module: `peak_chop_regulator`

## Requirements
- R1: While reset is asserted and on the first sample after it, chop_en and hs_turn_on are low. When reset is released with pwm_in high, chop_en first rises one clock edge after release.
- R2: hs_turn_on is high for exactly the one cycle in which chop_en has just risen, and at no other time.
- R3: After every rising edge of chop_en, trip_in is ignored for blank_count+1 clock edges. A count of 0 gives one edge of blanking.
- R4: Once blanking has ended, with pwm_in high, trip_in high on a clock edge drops chop_en at that edge. The drive is on for exactly blank_count+2 cycles when trip_in is held high.
- R5: After a trip, chop_en stays low for exactly off_count+1 cycles and then rises again, which starts a new blanking window.
- R6: trip_in asserted during the off time neither extends nor restarts it.
- R7: pwm_in low on a clock edge makes chop_en low after that edge, from any state, and abandons a running off time. The next rise of pwm_in turns the drive on one edge later with a fresh blanking window.
- R8: With pwm_in held high and trip_in low, chop_en stays high without limit once it has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | External speed PWM; low forces the drive off |
| trip_in | input | 1 | Current comparator flag; high when sense is at or above reference |
| blank_count | input | CNT_W | Blanking length minus one, in cycles |
| off_count | input | CNT_W | Off time minus one, in cycles |
| chop_en | output | 1 | Source enable to the gate sequencer |
| hs_turn_on | output | 1 | One-cycle pulse on each high-side turn-on |

## Verification
A wrong state or counter value shows up on chop_en within one chop period:
- An off-by-one in the blank or off count makes a high or low run one cycle too long or too short.
- A trip honoured during blanking or during the off time cuts a run short or lengthens it.

The sweep holds trip_in high and compares every sampled cycle with a period worked out from the two counts. A wrong run length therefore fails on the first cycle it touches, and a missing or extra turn-on pulse is caught on the same cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        CHOP_IDLE  = 2'd0,
        CHOP_BLANK = 2'd1,
        CHOP_ARMED = 2'd2,
        CHOP_OFF   = 2'd3
    } chop_state_e;

endpackage

// File: rtl/chop_interval_counter.sv
module chop_interval_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_zero
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (clr) begin
            cnt_q <= ZERO;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != ZERO)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_zero = (cnt_q == ZERO);

endmodule

// File: rtl/chop_sequencer.sv
module chop_sequencer
    import chop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwm_in,
    input  logic        trip_in,
    input  logic        cnt_zero,
    output chop_state_e state,
    output logic        cnt_clr,
    output logic        cnt_load,
    output logic        load_off,
    output logic        cnt_dec,
    output logic        chop_en,
    output logic        hs_turn_on
);

    chop_state_e state_q;
    chop_state_e state_d;

    // next-state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_load = 1'b0;
        load_off = 1'b0;
        cnt_dec  = 1'b0;
        if (!pwm_in) begin
            state_d = CHOP_IDLE;           // GATE
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                CHOP_IDLE: begin
                    state_d  = CHOP_BLANK;  // START
                    cnt_load = 1'b1;
                end
                CHOP_BLANK: begin
                    if (cnt_zero) begin
                        state_d = CHOP_ARMED; // ARM
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                CHOP_ARMED: begin
                    if (trip_in) begin
                        state_d  = CHOP_OFF;  // TRIP
                        cnt_load = 1'b1;
                        load_off = 1'b1;
                    end
                end
                CHOP_OFF: begin
                    if (cnt_zero) begin
                        state_d  = CHOP_BLANK; // RESUME
                        cnt_load = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                default: begin
                    state_d = CHOP_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CHOP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chop_en    <= 1'b0;
            hs_turn_on <= 1'b0;
        end else begin
            chop_en    <= (state_d == CHOP_BLANK) || (state_d == CHOP_ARMED);
            hs_turn_on <= (state_d == CHOP_BLANK) && (state_q != CHOP_BLANK);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/peak_chop_regulator.sv
module peak_chop_regulator #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic             trip_in,
    input  logic [CNT_W-1:0] blank_count,
    input  logic [CNT_W-1:0] off_count,
    output logic             chop_en,
    output logic             hs_turn_on
);

    chop_pkg::chop_state_e fsm_state;
    logic                  cnt_zero;
    logic                  cnt_clr;
    logic                  cnt_load;
    logic                  load_off;
    logic                  cnt_dec;
    logic [CNT_W-1:0]      load_val;

    assign load_val = load_off ? off_count : blank_count;

    chop_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_in     (pwm_in),
        .trip_in    (trip_in),
        .cnt_zero   (cnt_zero),
        .state      (fsm_state),
        .cnt_clr    (cnt_clr),
        .cnt_load   (cnt_load),
        .load_off   (load_off),
        .cnt_dec    (cnt_dec),
        .chop_en    (chop_en),
        .hs_turn_on (hs_turn_on)
    );

    chop_interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (load_val),
        .dec      (cnt_dec),
        .cnt_zero (cnt_zero)
    );

endmodule

// File: rtl/peak_chop_checker.sv
module peak_chop_checker
    import chop_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        pwm_in,
    input logic        trip_in,
    input logic        chop_en,
    input logic        hs_turn_on,
    input chop_state_e fsm_state,
    input logic        cnt_zero
);

    // R7
    pwm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_in |=> !chop_en);

    // R2
    turn_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_turn_on |-> $rose(chop_en));

    // R2
    rise_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chop_en) |-> hs_turn_on);

    // R3
    blank_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == CHOP_BLANK && pwm_in && trip_in) |=> chop_en);

    // R4
    trip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == CHOP_ARMED && trip_in) |=> !chop_en);

    // R6
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == CHOP_OFF && !cnt_zero) |=> !chop_en);

    // R8
    no_trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_en && pwm_in && !trip_in && fsm_state == CHOP_ARMED) |=> chop_en);

endmodule

bind peak_chop_regulator peak_chop_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_in     (pwm_in),
    .trip_in    (trip_in),
    .chop_en    (chop_en),
    .hs_turn_on (hs_turn_on),
    .fsm_state  (fsm_state),
    .cnt_zero   (cnt_zero)
);

// File: tb/peak_chop_regulator_bench.sv
`timescale 1ns/1ps
module peak_chop_regulator_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_in = 1'b0;
    logic          trip_in = 1'b0;
    logic [CW-1:0] blank_count = '0;
    logic [CW-1:0] off_count = '0;
    logic          chop_en;
    logic          hs_turn_on;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    peak_chop_regulator #(.CNT_W(CW)) u_peak_chop_regulator (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .trip_in(trip_in),
        .blank_count(blank_count), .off_count(off_count),
        .chop_en(chop_en), .hs_turn_on(hs_turn_on)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        pwm_in = 1'b0;
        trip_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // trip held high: compare each cycle with the computed period
    task automatic sweep_combo(input int b, input int o);
        int hi_len = b + 2;
        int per = b + 2 + o + 1;
        int chop_err = 0;
        int pulse_err = 0;
        go_idle();
        blank_count = CW'(b);
        off_count = CW'(o);
        pwm_in = 1'b1;
        trip_in = 1'b1;
        for (int k = 0; k < 3 * per; k++) begin
            @(negedge clk);
            if (int'(chop_en) != int'((k % per) < hi_len)) chop_err++;
            if (int'(hs_turn_on) != int'((k % per) == 0)) pulse_err++;
        end
        // R3 R4 R5 R6: run lengths of chop_en
        check($sformatf("R4/R5 b=%0d o=%0d chop mismatches", b, o), chop_err, 0);
        // R2: turn-on pulse only on each rise
        check($sformatf("R2 b=%0d o=%0d pulse mismatches", b, o), pulse_err, 0);
    endtask

    initial begin
        // R1: reset state with pwm high already
        pwm_in = 1'b1;
        blank_count = CW'(1);
        off_count = CW'(1);
        repeat (3) @(negedge clk);
        check("R1 chop during reset", int'(chop_en), 0);
        check("R1 pulse during reset", int'(hs_turn_on), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 chop after first edge", int'(chop_en), 1);
        check("R1 pulse after first edge", int'(hs_turn_on), 1);

        // R3 R4 R5 R6: sweep blank and off counts
        for (int b = 0; b < 6; b++) begin
            for (int o = 0; o < 6; o++) begin
                sweep_combo(b, o);
            end
        end

        // R8: no trip keeps the drive on
        begin
            int lows = 0;
            go_idle();
            blank_count = CW'(2);
            off_count = CW'(3);
            pwm_in = 1'b1;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (!chop_en) lows++;
            end
            check("R8 low cycles without trip", lows, 0);
            pwm_in = 1'b0;
            @(negedge clk);
            check("R7 pwm low from armed", int'(chop_en), 0);
        end

        // R7: pwm low aborts off time, rise restarts blanking
        begin
            int seq_err = 0;
            go_idle();
            pwm_in = 1'b1;
            trip_in = 1'b1;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (int'(chop_en) != int'(k < 4)) seq_err++;
            end
            check("R7 first run before gating", seq_err, 0);
            pwm_in = 1'b0;
            trip_in = 1'b0;
            @(negedge clk);
            check("R7 pwm low during off", int'(chop_en), 0);
            repeat (2) @(negedge clk);
            pwm_in = 1'b1;
            trip_in = 1'b1;
            seq_err = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (int'(chop_en) != int'(k < 4)) seq_err++;
                if (int'(hs_turn_on) != int'(k == 0)) seq_err++;
            end
            check("R7 fresh blank after pwm rise", seq_err, 0);
        end

        // R3: trip only inside the blank window is forgotten
        begin
            int lows = 0;
            go_idle();
            blank_count = CW'(4);
            off_count = CW'(2);
            pwm_in = 1'b1;
            trip_in = 1'b1;
            for (int k = 0; k < 4; k++) @(negedge clk);
            trip_in = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (!chop_en) lows++;
            end
            check("R3 low cycles after blank-only trip", lows, 0);
        end

        // R6: a single trip pulse mid off time does not stretch it
        begin
            int seq_err = 0;
            go_idle();
            blank_count = CW'(0);
            off_count = CW'(4);
            pwm_in = 1'b1;
            trip_in = 1'b0;
            repeat (4) @(negedge clk);
            trip_in = 1'b1;
            @(negedge clk);
            check("R4 single trip drops chop", int'(chop_en), 0);
            trip_in = 1'b0;
            repeat (2) @(negedge clk);
            trip_in = 1'b1;
            @(negedge clk);
            trip_in = 1'b0;
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                if (int'(chop_en) != int'(k == 1)) seq_err++;
            end
            check("R6 off length after mid-off trip", seq_err, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule